// File: doc/BRIEF.md
# Firmware Watchdog with Safe-State Output Override

This block supervises embedded firmware with a countdown watchdog that steps once per 25 ms time-base tick. Firmware restarts the countdown by writing a restart bit; if it fails to do so before the count runs out, the block enters a latched safe mode. A thermal-event input can also trigger safe mode, but only while thermal entry is enabled. The remaining count is always readable, and the remaining time equals (count + 1) ticks.

In safe mode, every controlled output channel takes a programmed 2-bit safe state that replaces its normal drive. There are four analog-output channel controls and two general-purpose pins. The four states are: hold what the channel was driving when safe mode began, release the channel to high impedance, drive it low, or drive it high. A general-purpose pin can therefore be left as an input or forced to either level. Safe mode stays set until firmware clears it with an explicit write.

Register writes use a simple strobe, a 2-bit address and a data byte. Address 0 is control: bit 0 enables the watchdog, bit 1 restarts it when written as 1, bit 2 enables thermal entry, and bit 3 clears safe mode when written as 1. Address 1 holds the length. Address 2 holds the analog-channel safe states. Address 3 holds the pin safe states.

Top module: `wdog_safe_ovr`

## Requirements
- R1: After reset the count and the length both read 255, the watchdog and thermal entry are disabled, and safe mode is 0. While the watchdog is enabled, each tick at a nonzero count lowers `wd_cnt` by one, visible the cycle after the tick.
- R2: A control write with bit 1 set loads `wd_cnt` from the length register (address 1, bits 7:0) on the next cycle, whether or not the watchdog is enabled. The restart wins over a tick in the same cycle, including a tick at count 0, so no expiry occurs.
- R3: While control bit 0 is 0, ticks leave `wd_cnt` unchanged and the watchdog never sets safe mode.
- R4: With the watchdog enabled, a tick at count 0 with no restart in that cycle sets `safe_mode` on the next cycle and reloads the count from the length. Safe mode is therefore reached exactly length + 1 ticks after a restart.
- R5: A cycle with `therm_evt` high sets `safe_mode` on the next cycle when control bit 2 is 1. When control bit 2 is 0, it has no effect.
- R6: `safe_mode` stays set until a control write with bit 3 set. If an entry condition occurs in the same cycle as the clear, the entry wins.
- R7: `ovr_en` is all ones while `safe_mode` is 1. While `safe_mode` is 0, `ovr_en`, `ovr_oe` and `ovr_val` are all zero.
- R8: In safe mode, the channel state codes act as follows: 01 gives oe=0, val=0 (high impedance); 10 gives oe=1, val=0; 11 gives oe=1, val=1.
- R9: State code 00 holds the `norm_oe`/`norm_val` values sampled in the cycle safe mode was entered. Later changes on those inputs do not alter the channel.
- R10: Analog channel i takes its code from address 2, bits [2i+1:2i], and drives output bit i. Pin j takes its code from address 3, bits [2j+1:2j], and drives output bit 4+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 25 ms time-base pulse |
| therm_evt | input | 1 | Thermal event request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| norm_oe | input | 6 | Normal output enable per channel |
| norm_val | input | 6 | Normal output value per channel |
| ovr_en | output | 6 | Override active per channel |
| ovr_oe | output | 6 | Override output enable per channel |
| ovr_val | output | 6 | Override output value per channel |
| safe_mode | output | 1 | Safe mode latched |
| wd_cnt | output | 8 | Remaining count; remaining time is (wd_cnt + 1) ticks |

## Verification
The bench sweeps the length across 0 to 15 and 255. It counts the ticks from a restart to safe mode. A design off by one in the expiry test would fire a tick early or a tick late, and one that failed to reload would show the wrong count after expiry. It also issues a restart in the same cycle as a tick at count 0. A design that gave the tick priority there would enter safe mode even though firmware had restarted in time. Every state code is rotated through every channel, and the normal drive is inverted after entry. A wrong field position would show up as a swapped channel, and a maintain state that failed to latch would follow the live inputs. A clear in the same cycle as a thermal event checks that a design letting the clear win does not drop safe mode.

// File: rtl/wso_pkg.sv
// Shared encodings for the watchdog and safe-state override block.
// Assumes a 2-bit register address space and byte-wide control fields.
package wso_pkg;
    typedef enum logic [1:0] {
        SS_KEEP = 2'b00,
        SS_HIZ  = 2'b01,
        SS_LOW  = 2'b10,
        SS_HIGH = 2'b11
    } safe_st_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LEN  = 2'd1;
    localparam logic [1:0] ADDR_ANA  = 2'd2;
    localparam logic [1:0] ADDR_PIN  = 2'd3;

    localparam int CTL_EN    = 0;
    localparam int CTL_KICK  = 1;
    localparam int CTL_THERM = 2;
    localparam int CTL_CLR   = 3;
endpackage

// File: rtl/wso_regs.sv
// Configuration registers: enables, length and per-channel safe states.
// Restart and clear are one-cycle pulses taken straight from the write.
// Assumes DW is at least max(CNT_W, 2*N_ANA, 2*N_PIN, 4).
module wso_regs import wso_pkg::*; #(
    parameter int CNT_W = 8,
    parameter int N_ANA = 4,
    parameter int N_PIN = 2,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [1:0]                   addr,
    input  logic [DW-1:0]                wdata,
    output logic                         dog_en,
    output logic                         therm_en,
    output logic                         kick,
    output logic                         clr,
    output logic [CNT_W-1:0]             len,
    output logic [2*(N_ANA+N_PIN)-1:0]   st
);
    localparam int AW = 2 * N_ANA;
    localparam int PW = 2 * N_PIN;

    logic wr_ctrl;

    // Decode a control write; the pulses are suppressed during reset.
    always_comb begin
        wr_ctrl = rst_n && wr && (addr == ADDR_CTRL);
        kick    = wr_ctrl && wdata[CTL_KICK];
        clr     = wr_ctrl && wdata[CTL_CLR];
    end

    // Hold the stored configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dog_en   <= 1'b0;
            therm_en <= 1'b0;
            len      <= '1;
            st       <= '0;
        end else if (wr) begin
            case (addr)
                ADDR_CTRL: begin
                    dog_en   <= wdata[CTL_EN];
                    therm_en <= wdata[CTL_THERM];
                end
                ADDR_LEN: len           <= wdata[CNT_W-1:0];
                ADDR_ANA: st[AW-1:0]    <= wdata[AW-1:0];
                default:  st[AW+PW-1:AW] <= wdata[PW-1:0];
            endcase
        end
    end
endmodule

// File: rtl/wso_dog.sv
// Countdown watchdog: steps on each enabled tick, reloads on restart or
// on expiry. Expiry is a tick at count zero with no restart that cycle.
module wso_dog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    // Flag a timeout on the tick that finds the counter exhausted.
    always_comb expire = en && tick && !kick && (cnt == '0);

    // Advance, reload or hold the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (kick)
            cnt <= len;
        else if (en && tick)
            cnt <= (cnt == '0) ? len : cnt - 1'b1;
    end
endmodule

// File: rtl/wso_chan.sv
// One overridden output channel. It latches the normal drive on safe-mode
// entry and maps the 2-bit safe-state code to enable and value.
module wso_chan import wso_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       safe,
    input  logic       enter,
    input  logic [1:0] st,
    input  logic       norm_oe,
    input  logic       norm_val,
    output logic       o_en,
    output logic       o_oe,
    output logic       o_val
);
    logic h_oe, h_val;

    // Capture the live drive at the moment safe mode begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_oe  <= 1'b0;
            h_val <= 1'b0;
        end else if (enter) begin
            h_oe  <= norm_oe;
            h_val <= norm_val;
        end
    end

    // Decode the safe state into the override drive.
    always_comb begin
        o_en  = safe;
        o_oe  = 1'b0;
        o_val = 1'b0;
        if (safe) begin
            case (safe_st_e'(st))
                SS_KEEP: begin o_oe = h_oe; o_val = h_val; end
                SS_HIZ:  begin o_oe = 1'b0; o_val = 1'b0;  end
                SS_LOW:  begin o_oe = 1'b1; o_val = 1'b0;  end
                default: begin o_oe = 1'b1; o_val = 1'b1;  end
            endcase
        end
    end
endmodule

// File: rtl/wdog_safe_ovr.sv
// Top: watchdog plus thermal entry latch a safe mode that overrides four
// analog-channel controls (bits 0..N_ANA-1) and general pins (above).
// Assumes tick is a one-cycle pulse per 25 ms; synchronous active-low reset.
module wdog_safe_ovr import wso_pkg::*; #(
    parameter int CNT_W = 8,
    parameter int N_ANA = 4,
    parameter int N_PIN = 2,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     therm_evt,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    input  logic [N_ANA+N_PIN-1:0]   norm_oe,
    input  logic [N_ANA+N_PIN-1:0]   norm_val,
    output logic [N_ANA+N_PIN-1:0]   ovr_en,
    output logic [N_ANA+N_PIN-1:0]   ovr_oe,
    output logic [N_ANA+N_PIN-1:0]   ovr_val,
    output logic                     safe_mode,
    output logic [CNT_W-1:0]         wd_cnt
);
    localparam int N_CH = N_ANA + N_PIN;

    logic             dog_en, therm_en, kick, clr, expire, trig, enter;
    logic [CNT_W-1:0] len;
    logic [2*N_CH-1:0] ch_st;

    wso_regs #(.CNT_W(CNT_W), .N_ANA(N_ANA), .N_PIN(N_PIN), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .dog_en(dog_en), .therm_en(therm_en),
        .kick(kick), .clr(clr), .len(len), .st(ch_st)
    );

    wso_dog #(.CNT_W(CNT_W)) u_dog (
        .clk(clk), .rst_n(rst_n), .en(dog_en), .tick(tick), .kick(kick),
        .len(len), .cnt(wd_cnt), .expire(expire)
    );

    // Combine entry causes; capture only on the first entry.
    always_comb begin
        trig  = expire || (therm_evt && therm_en);
        enter = trig && !safe_mode;
    end

    // Sticky safe-mode flag; a new entry outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            safe_mode <= 1'b0;
        else if (trig)
            safe_mode <= 1'b1;
        else if (clr)
            safe_mode <= 1'b0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        wso_chan u_ch (
            .clk(clk), .rst_n(rst_n), .safe(safe_mode), .enter(enter),
            .st(ch_st[2*c+1:2*c]), .norm_oe(norm_oe[c]), .norm_val(norm_val[c]),
            .o_en(ovr_en[c]), .o_oe(ovr_oe[c]), .o_val(ovr_val[c])
        );
    end
endmodule

// File: rtl/wso_chk.sv
// Property checker for wdog_safe_ovr, attached by bind below.
module wso_chk #(
    parameter int CNT_W = 8,
    parameter int N_CH  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             therm_evt,
    input logic             dog_en,
    input logic             therm_en,
    input logic             kick,
    input logic             clr,
    input logic             expire,
    input logic [CNT_W-1:0] len,
    input logic [CNT_W-1:0] wd_cnt,
    input logic             safe_mode,
    input logic [1:0]       st0,
    input logic [N_CH-1:0]  ovr_en,
    input logic [N_CH-1:0]  ovr_oe,
    input logic [N_CH-1:0]  ovr_val
);
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dog_en && tick && !kick && wd_cnt != '0) |=> wd_cnt == $past(wd_cnt) - 1'b1); // R1
    AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> wd_cnt == $past(len)); // R2
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dog_en && !kick) |=> $stable(wd_cnt)); // R3
    AST_TIMEOUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (dog_en && tick && !kick && wd_cnt == '0) |=> safe_mode); // R4
    AST_THERM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_evt && !therm_en && !expire && !safe_mode) |=> !safe_mode); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_mode && !clr) |=> safe_mode); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !safe_mode |-> (ovr_en == '0 && ovr_oe == '0 && ovr_val == '0)); // R7
    AST_HIZ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_mode && st0 == 2'b01) |-> (!ovr_oe[0] && ovr_en[0])); // R8
endmodule

bind wdog_safe_ovr wso_chk #(.CNT_W(CNT_W), .N_CH(N_ANA + N_PIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .therm_evt(therm_evt),
    .dog_en(dog_en), .therm_en(therm_en), .kick(kick), .clr(clr),
    .expire(expire), .len(len), .wd_cnt(wd_cnt), .safe_mode(safe_mode),
    .st0(ch_st[1:0]), .ovr_en(ovr_en), .ovr_oe(ovr_oe), .ovr_val(ovr_val)
);

// File: tb/wdog_safe_ovr_tb.sv
// Self-checking bench: length sweep, restart/tick race, enable gating,
// sticky latch and a rotation of every safe-state code over every channel.
module wdog_safe_ovr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       therm_evt = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [5:0] norm_oe = 6'd0;
    logic [5:0] norm_val = 6'd0;
    logic [5:0] ovr_en, ovr_oe, ovr_val;
    logic       safe_mode;
    logic [7:0] wd_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_safe_ovr dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .therm_evt(therm_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .norm_oe(norm_oe), .norm_val(norm_val), .ovr_en(ovr_en),
        .ovr_oe(ovr_oe), .ovr_val(ovr_val), .safe_mode(safe_mode),
        .wd_cnt(wd_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input bit en, input bit kk, input bit th, input bit cl);
        return {4'd0, cl, th, kk, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_therm();
        therm_evt = 1'b1;
        @(negedge clk);
        therm_evt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", int'(wd_cnt), 255);
        chk("R1 reset safe", int'(safe_mode), 0);
        chk("R7 reset ovr_en", int'(ovr_en), 0);

        // R3: disabled watchdog holds and never fires
        for (int i = 0; i < 20; i++) pulse_tick();
        chk("R3 disabled count", int'(wd_cnt), 255);
        chk("R3 disabled safe", int'(safe_mode), 0);

        // R5: thermal event ignored when gate off
        pulse_therm();
        chk("R5 gated thermal", int'(safe_mode), 0);

        // R1 R2 R4: length sweep
        for (int idx = 0; idx <= 16; idx++) begin
            int L;
            L = (idx < 16) ? idx : 255;
            wr(ADDR_LEN_TB, 8'(L));
            wr(2'd0, ctl(1, 1, 0, 1));
            chk("R2 kick load", int'(wd_cnt), L);
            for (int k = 0; k <= L; k++) begin
                chk("R1 count step", int'(wd_cnt), L - k);
                chk("R4 not early", int'(safe_mode), 0);
                pulse_tick();
            end
            chk("R4 expiry entry", int'(safe_mode), 1);
            chk("R4 reload after expiry", int'(wd_cnt), L);
            wr(2'd0, ctl(0, 0, 0, 1));
            chk("R6 clear", int'(safe_mode), 0);
        end

        // R2: restart races tick at count zero
        wr(ADDR_LEN_TB, 8'd3);
        wr(2'd0, ctl(1, 1, 0, 0));
        for (int i = 0; i < 3; i++) pulse_tick();
        chk("R1 at zero", int'(wd_cnt), 0);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ctl(1, 1, 0, 0);
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        chk("R2 kick beats tick safe", int'(safe_mode), 0);
        chk("R2 kick beats tick count", int'(wd_cnt), 3);

        // R3: disable mid count, then resume
        wr(2'd0, ctl(0, 0, 0, 0));
        for (int i = 0; i < 5; i++) pulse_tick();
        chk("R3 hold mid count", int'(wd_cnt), 3);
        wr(2'd0, ctl(1, 0, 0, 0));
        pulse_tick();
        chk("R1 resume step", int'(wd_cnt), 2);
        wr(2'd0, ctl(0, 0, 1, 0));

        // R5 R6: thermal entry, stickiness, entry beats clear
        pulse_therm();
        chk("R5 thermal entry", int'(safe_mode), 1);
        repeat (10) @(negedge clk);
        chk("R6 sticky", int'(safe_mode), 1);
        therm_evt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ctl(0, 0, 1, 1);
        @(negedge clk);
        therm_evt = 1'b0; reg_wr = 1'b0;
        chk("R6 entry beats clear", int'(safe_mode), 1);
        wr(2'd0, ctl(0, 0, 1, 1));
        chk("R6 clear works", int'(safe_mode), 0);

        // R7 R8 R9 R10: rotate codes over channels
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ana;
            logic [3:0] pin;
            logic [5:0] pre_oe, pre_val;
            int code [6];
            for (int c = 0; c < 6; c++) code[c] = (c + k) % 4;
            ana = 8'((code[0]) | (code[1] << 2) | (code[2] << 4) | (code[3] << 6));
            pin = 4'((code[4]) | (code[5] << 2));
            wr(2'd2, ana);
            wr(2'd3, {4'd0, pin});
            pre_oe  = 6'(k * 7 + 3);
            pre_val = 6'(k * 13 + 5);
            norm_oe = pre_oe; norm_val = pre_val;
            @(negedge clk);
            chk("R7 idle ovr_en", int'(ovr_en), 0);
            chk("R7 idle ovr_oe", int'(ovr_oe), 0);
            pulse_therm();
            norm_oe = ~pre_oe; norm_val = ~pre_val;
            @(negedge clk);
            chk("R7 safe ovr_en", int'(ovr_en), 63);
            for (int c = 0; c < 6; c++) begin
                int eo, ev;
                case (code[c])
                    0: begin eo = int'(pre_oe[c]); ev = int'(pre_val[c]); end
                    1: begin eo = 0; ev = 0; end
                    2: begin eo = 1; ev = 0; end
                    default: begin eo = 1; ev = 1; end
                endcase
                chk((code[c] == 0) ? "R9 maintain oe" : "R8 R10 code oe", int'(ovr_oe[c]), eo);
                chk((code[c] == 0) ? "R9 maintain val" : "R8 R10 code val", int'(ovr_val[c]), ev);
            end
            wr(2'd0, ctl(0, 0, 1, 1));
            chk("R7 cleared ovr_en", int'(ovr_en), 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    localparam logic [1:0] ADDR_LEN_TB = 2'd1;
endmodule